// File: doc/BRIEF.md
# Two-Mode Pulse Accumulator

This block keeps a 16-bit running total driven by a single input pin. In event mode it adds one for every selected transition of the pin, which suits counting parts or pulses. In gated mode it adds one for each tick of a free-running divide-by-64 clock divider, but only while the pin sits at its active level. This measures how long the pin stays active, in units of 64 clocks.

A single polarity bit selects the edge or level. Value 0 selects falling edges in event mode, or counting while the pin is high in gated mode. Value 1 selects rising edges, or counting while the pin is low. In both modes the edge that raises the input-event flag is the one the polarity picks: the counted edge in event mode, and the trailing edge of the active phase in gated mode. Software may load the total at any moment. Rolling over from all ones to zero raises an overflow flag.

Both flags are cleared by writing a one to the matching clear bit. Each flag has its own interrupt enable, and these feed one combined interrupt line. Loading the two's complement of N before an active phase produces an overflow after exactly N ticks.

Top module: `pulse_acc`

## Requirements
- R1: While reset is high and on the first cycle after it, `count` is 0, both flags are 0 and `irq` is 0.
- R2: With `cfg_enable` at 0, pin activity changes neither `count` nor either flag.
- R3: In event mode (`cfg_gated`=0), `cfg_pol`=0 counts falling edges of `pin` and `cfg_pol`=1 counts rising edges. The other edge has no effect. Each counted edge sets `flag_in`. The new count is visible after the second rising clock edge that follows the pin change.
- R4: In gated mode with `cfg_pol`=0, ticks are counted only while `pin` is high. The falling edge that ends the high phase sets `flag_in`. While the pin stays low, the count holds.
- R5: In gated mode with `cfg_pol`=1, ticks are counted only while `pin` is low. The rising edge that ends the low phase sets `flag_in`.
- R6: The tick comes from a free-running divider of period 64 clocks that ignores the gate. An active phase lasting exactly 64·N clocks therefore adds exactly N, whatever its phase.
- R7: An increment from 0xFFFF gives 0x0000 and sets `flag_ovf`.
- R8: Pulsing `flag_clr[0]` clears `flag_in`, and pulsing `flag_clr[1]` clears `flag_ovf`. A new set event arriving in the same cycle as a clear wins.
- R9: `irq` equals (`flag_in` AND `ie_in`) OR (`flag_ovf` AND `ie_ovf`).
- R10: A write (`cnt_wr_en`=1) loads `cnt_wr_data` on the next edge in any mode. It takes priority over an increment in the same cycle.
- R11: In gated mode, preloading 0x10000−N sets `flag_ovf` after exactly N active ticks and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | 1 turns the accumulator on |
| cfg_gated | input | 1 | 0 selects event mode, 1 selects gated mode |
| cfg_pol | input | 1 | Edge / active-level selection |
| cnt_wr_en | input | 1 | Load strobe for the count |
| cnt_wr_data | input | 16 | Value to load |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears the input flag, bit 1 clears the overflow flag |
| ie_in | input | 1 | Interrupt enable for the input flag |
| ie_ovf | input | 1 | Interrupt enable for the overflow flag |
| pin | input | 1 | Accumulator input pin |
| count | output | 16 | Current total |
| flag_in | output | 1 | Input-event flag |
| flag_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A bad pin history register appears at the ports as a count that moves on the wrong edge, or that misses an edge, two clocks after the pin changes. A bad flag register shows at once on `irq` whenever the matching enable is set. A divider with the wrong phase cannot be seen in any window of whole periods. A divider with the wrong period shows up as a count error after a single multi-tick gated phase. A broken wrap shows up when a preload of 0xFFFF is followed by one more increment: the overflow flag stays clear.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int CNT_W    = 16;
    localparam int TICK_DIV = 64;

    typedef struct packed {
        logic enable;
        logic gated;
        logic pol;
    } pacc_cfg_t;

    typedef struct packed {
        logic inc;
        logic sel_edge;
    } pacc_evt_t;

    function automatic logic level_active(logic lvl, logic pol);
        return lvl ^ pol;
    endfunction
endpackage

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/pacc_detect.sv
module pacc_detect
    import pacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  pacc_cfg_t cfg,
    input  logic      tick,
    output pacc_evt_t evt
);
    logic pin_s;
    logic pin_d;
    logic rise;
    logic fall;
    logic chosen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_s <= 1'b0;
            pin_d <= 1'b0;
        end else begin
            pin_s <= pin;
            pin_d <= pin_s;
        end
    end

    assign rise   = pin_s & ~pin_d;
    assign fall   = ~pin_s & pin_d;
    assign chosen = cfg.pol ? rise : fall;

    always_comb begin
        evt.sel_edge = cfg.enable & chosen;
        if (cfg.gated)
            evt.inc = cfg.enable & tick & level_active(pin_s, cfg.pol);
        else
            evt.inc = cfg.enable & chosen;
    end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (wr_en)
            value <= wr_data;
        else if (inc)
            value <= value + 1'b1;
    end

    assign wrap = inc & ~wr_en & (value == ALL_ONES);
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_gated,
    input  logic             cfg_pol,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic [1:0]       flag_clr,
    input  logic             ie_in,
    input  logic             ie_ovf,
    input  logic             pin,
    output logic [CNT_W-1:0] count,
    output logic             flag_in,
    output logic             flag_ovf,
    output logic             irq
);
    pacc_cfg_t cfg;
    pacc_evt_t evt;
    logic      tick;
    logic      wrap;

    assign cfg = '{enable: cfg_enable, gated: cfg_gated, pol: cfg_pol};

    pacc_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pacc_detect u_det (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin),
        .cfg  (cfg),
        .tick (tick),
        .evt  (evt)
    );

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (evt.inc),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .value   (count),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_in  <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_in  <= evt.sel_edge | (flag_in  & ~flag_clr[0]);
            flag_ovf <= wrap         | (flag_ovf & ~flag_clr[1]);
        end
    end

    assign irq = (flag_in & ie_in) | (flag_ovf & ie_ovf);
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_enable,
    input logic        cnt_wr_en,
    input logic [15:0] cnt_wr_data,
    input logic [15:0] count,
    input logic        flag_in,
    input logic        flag_ovf,
    input logic        irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == 16'h0000 && !flag_in && !flag_ovf));

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !cnt_wr_en) |=> $stable(count));

    assert_disabled_noflag_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !flag_in) |=> !flag_in);

    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr_en |=> (count == $past(count) || count == $past(count) + 16'd1));

    assert_wrap_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (count == 16'hFFFF && !cnt_wr_en) ##1 (count == 16'h0000) |-> flag_ovf);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_in || flag_ovf));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_en |=> (count == $past(cnt_wr_data)));
endmodule

bind pulse_acc pacc_checker u_pacc_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .count       (count),
    .flag_in     (flag_in),
    .flag_ovf    (flag_ovf),
    .irq         (irq)
);

// File: tb/pulse_acc_test.sv
module pulse_acc_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TICKS      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0, cfg_gated = 1'b0, cfg_pol = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic [1:0]  flag_clr = '0;
    logic        ie_in = 1'b0, ie_ovf = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] count;
    logic        flag_in, flag_ovf, irq;

    typedef struct {
        string       req;
        logic [15:0] cnt;
        logic        fi;
        logic        fo;
        logic        ir;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_acc uut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_gated(cfg_gated),
        .cfg_pol(cfg_pol), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .flag_clr(flag_clr), .ie_in(ie_in), .ie_ovf(ie_ovf), .pin(pin),
        .count(count), .flag_in(flag_in), .flag_ovf(flag_ovf), .irq(irq)
    );

    // monitor: pops expected items and compares at the moment they are pushed
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            n_cmp++;
            if (count !== e.cnt || flag_in !== e.fi || flag_ovf !== e.fo || irq !== e.ir) begin
                n_bad++;
                $display("FAIL %s: count=%h fi=%b fo=%b irq=%b expected count=%h fi=%b fo=%b irq=%b",
                         e.req, count, flag_in, flag_ovf, irq, e.cnt, e.fi, e.fo, e.ir);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(string r, logic [15:0] c, logic fi, logic fo, logic ir);
        @(negedge clk);
        q.push_back('{r, c, fi, fo, ir});
        #1;
    endtask

    task automatic set_pin(logic v);
        step();
        pin = v;
        repeat (3) step();
    endtask

    task automatic load(logic [15:0] v);
        step();
        cnt_wr_en = 1'b1;
        cnt_wr_data = v;
        step();
        cnt_wr_en = 1'b0;
    endtask

    task automatic clear(logic [1:0] m);
        step();
        flag_clr = m;
        step();
        flag_clr = 2'b00;
    endtask

    task automatic configure(logic en, logic g, logic p);
        step();
        cfg_enable = en;
        cfg_gated = g;
        cfg_pol = p;
    endtask

    // active phase of exactly n divider periods, then back to the idle level
    task automatic active_window(logic act, int n);
        step();
        pin = act;
        repeat (n * TICKS) @(posedge clk);
        #1;
        pin = ~act;
        repeat (4) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        expect_state("R1 in reset", 16'h0000, 0, 0, 0);
        rst = 1'b0;
        expect_state("R1 after reset", 16'h0000, 0, 0, 0);

        set_pin(1); set_pin(0);
        expect_state("R2 disabled event pin", 16'h0000, 0, 0, 0);

        configure(1, 0, 0);
        set_pin(1);
        expect_state("R3 rising ignored pol0", 16'h0000, 0, 0, 0);
        set_pin(0);
        expect_state("R3 falling counted pol0", 16'h0001, 1, 0, 0);
        step(); ie_in = 1'b1;
        expect_state("R9 input irq", 16'h0001, 1, 0, 1);
        clear(2'b01);
        expect_state("R8 clear input flag", 16'h0001, 0, 0, 0);

        configure(1, 0, 1);
        set_pin(1);
        expect_state("R3 rising counted pol1", 16'h0002, 1, 0, 1);
        clear(2'b01);
        set_pin(0);
        expect_state("R3 falling ignored pol1", 16'h0002, 0, 0, 0);

        load(16'hFFFE);
        expect_state("R10 load", 16'hFFFE, 0, 0, 0);
        set_pin(1);
        expect_state("R7 to FFFF", 16'hFFFF, 1, 0, 1);
        set_pin(0); set_pin(1);
        expect_state("R7 wrap sets overflow", 16'h0000, 1, 1, 1);
        step(); ie_in = 1'b0;
        expect_state("R9 irq masked", 16'h0000, 1, 1, 0);
        step(); ie_ovf = 1'b1;
        expect_state("R9 overflow irq", 16'h0000, 1, 1, 1);
        clear(2'b11);
        expect_state("R8 clear both", 16'h0000, 0, 0, 0);

        set_pin(0);
        // pin rise increments on the same edge as the load
        step(); pin = 1'b1;
        step(); cnt_wr_en = 1'b1; cnt_wr_data = 16'h1234;
        step(); cnt_wr_en = 1'b0;
        repeat (2) step();
        expect_state("R10 write beats increment", 16'h1234, 1, 0, 0);
        clear(2'b01);
        set_pin(0);

        configure(1, 1, 0);
        load(16'h0000);
        clear(2'b11);
        active_window(1'b1, 5);
        expect_state("R4 R6 gated high five ticks", 16'h0005, 1, 0, 0);
        repeat (200) step();
        expect_state("R4 low level holds", 16'h0005, 1, 0, 0);
        clear(2'b01);

        configure(0, 1, 0);
        set_pin(1);
        expect_state("R2 disabled gated", 16'h0005, 0, 0, 0);
        configure(1, 1, 1);
        load(16'h0000);
        clear(2'b11);
        active_window(1'b0, 3);
        expect_state("R5 R6 gated low three ticks", 16'h0003, 1, 0, 0);
        clear(2'b01);

        configure(0, 1, 0);
        set_pin(0);
        configure(1, 1, 0);
        load(16'hFFFD);
        clear(2'b11);
        active_window(1'b1, 2);
        expect_state("R11 two of three ticks", 16'hFFFF, 1, 0, 0);
        active_window(1'b1, 1);
        expect_state("R11 third tick overflows", 16'h0000, 1, 1, 1);

        wait (q.size() == 0);
        #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule